// File: doc/BRIEF.md
# Tuner Control Register Slave

This block is the configuration port of a tuner. It listens to a two-wire I2C-compatible bus and stores twelve writable 8-bit control registers. Their contents are presented in parallel to the rest of the chip. A read transfer returns two status bytes collected from elsewhere on the chip. The top bit of the first status byte is a power-on flag owned by this block.

SCL and SDA are sampled on the system clock through two-flop synchronizers, and all bus events are found on the synchronized values. The system clock must run at least 8 times faster than SCL, and SCL may run at up to 400 kHz. SDA is open-drain: the block pulls the line low while `sda_oe_o` is high. A pin selects one of two device addresses, so that two tuners can share one bus. When register 0x04 is written, a single-cycle pulse is issued to start the VCO autoselect logic.

Top module: `tuner_ctrl_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `wr_strobe_o` is 0, and `regs_o` byte k (bits 8k+7:8k) holds the following defaults: k0=0x80, k1=0x23, k2=0x02, k3=0xF6, k4=0x84, k5=0x01, k6=0x80, k7=0xCC, k8=0x4B, k9=0x00, k10=0x00, k11=0x00.
- R2: The device address is 7'b1100000 when `addr_sel_i`=0 and 7'b1100001 when it is 1. It is sent MSB first after a START and is followed by an R/W bit (0 = write, 1 = read). A matching address byte is acknowledged by holding SDA low through the ninth SCL high period. `sda_oe_o` changes only while SCL is low.
- R3: An address byte that does not match gets no acknowledge. The block then ignores the bus until the next START, so the bytes that follow change no register.
- R4: In a write, the first byte after the address loads the register pointer. Each following byte (MSB first) is stored in the register the pointer selects, and the pointer then increments. The pointer byte and every data byte are acknowledged.
- R5: Data bytes aimed at a pointer of 12 or above are acknowledged but change no register.
- R6: Each data byte written to register 0x04 gives exactly one single-cycle pulse on `wr_strobe_o`. Writes to other registers give none.
- R7: A read has no pointer phase. It returns status byte 1 = {por_flag, `status1_i`[6:0]}, then status byte 2 = `status2_i`, both MSB first. SDA is released during the master's acknowledge slots.
- R8: If the master does not acknowledge status byte 1, the block drives no further bits until the next START.
- R9: The power-on flag is 1 after reset. It clears only at the STOP that ends a read in which both status bytes were sent. A read cut short after byte 1, or a write, leaves it set.
- R10: A repeated START in the middle of a transfer begins a new address phase. A pointer loaded before it does not cause any register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Selects the device address LSB |
| status1_i | input | 7 | Low seven bits of status byte 1 |
| status2_i | input | 8 | Status byte 2 |
| regs_o | output | 96 | Register k at bits 8k+7:8k |
| wr_strobe_o | output | 1 | Single-cycle pulse on a write to register 0x04 |

## Verification
A wrong bit counter or a wrong state shows at the port within one byte time. An acknowledge goes missing or lands on the wrong SCL pulse, or a read byte comes back shifted by one bit. A wrong pointer shows as data landing in the wrong register, which is visible on `regs_o` right after the byte's ninth clock. An error in the power-on flag shows only at the next read, one whole transfer later. For that reason the flag is checked across back-to-back reads, both with and without a complete second byte.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RD_ACK, ST_WAIT
  } link_state_e;

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h23;
      2:       return 8'h02;
      3:       return 8'hF6;
      4:       return 8'h84;
      5:       return 8'h01;
      6:       return 8'h80;
      7:       return 8'hCC;
      8:       return 8'h4B;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tcs_regfile.sv
module tcs_regfile
  import tcs_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 12,
  parameter int unsigned STROBE_IDX = 4,
  parameter int unsigned AW         = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic                       strobe_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= reg_default(g);
      else if (wr_en_i && (wr_addr_i == AW'(g)))     q <= wr_data_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_o <= 1'b0;
    else         strobe_o <= wr_en_i && (wr_addr_i == AW'(STROBE_IDX));
  end
endmodule

// File: rtl/tcs_link.sv
module tcs_link
  import tcs_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'b1100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  input  logic [6:0]        status1_i,
  input  logic [7:0]        status2_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              por_o,
  output logic              idle_o
);
  link_state_e state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [AW-1:0]     ptr_q;
  logic oe_q, rw_q, byte_idx_q, ack_q, rd_done_q, por_q;
  logic [6:0] my_addr;

  assign my_addr = {DEV_ADDR[6:1], DEV_ADDR[0] ^ addr_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      byte_idx_q <= 1'b0;
      ack_q      <= 1'b0;
      rd_done_q  <= 1'b0;
      por_q      <= 1'b1;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
      rd_done_q <= 1'b0;
      if (rd_done_q) por_q <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise_i) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          if (scl_fall_i && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            case (state_q)
              ST_ADDR: begin
                if (shift_q[7:1] == my_addr) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shift_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_PTR: begin
                ptr_q   <= AW'(shift_q);
                oe_q    <= 1'b1;
                state_q <= ST_PTR_ACK;
              end
              default: begin
                ptr_q   <= ptr_q + AW'(1);
                oe_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              shift_q    <= {por_q, status1_i};
              oe_q       <= ~por_q;
              byte_idx_q <= 1'b0;
              bit_cnt_q  <= '0;
              state_q    <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
              if (byte_idx_q) rd_done_q <= 1'b1;
            end else begin
              shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
              oe_q      <= ~shift_q[BYTE_W-2];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) ack_q <= ~sda_i;
          if (scl_fall_i) begin
            if (!byte_idx_q && ack_q) begin
              shift_q    <= status2_i;
              oe_q       <= ~status2_i[7];
              byte_idx_q <= 1'b1;
              bit_cnt_q  <= '0;
              state_q    <= ST_RDATA;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = (state_q == ST_WDATA) && scl_fall_i && (bit_cnt_q == 4'd8) && !start_i && !stop_i;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = shift_q;
  assign sda_oe_o  = oe_q;
  assign por_o     = por_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/tuner_ctrl_slave.sv
module tuner_ctrl_slave
  import tcs_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 12,
  parameter int unsigned STROBE_IDX  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'b1100000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic                       addr_sel_i,
  input  logic [6:0]                 status1_i,
  input  logic [7:0]                 status2_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic                       wr_strobe_o
);
  localparam int unsigned AW = BYTE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, por_flag, link_idle;
  logic [AW-1:0]     wr_addr;
  logic [BYTE_W-1:0] wr_data;

  tcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tcs_link #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .addr_sel_i, .status1_i, .status2_i,
    .sda_oe_o, .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .por_o(por_flag), .idle_o(link_idle)
  );

  tcs_regfile #(.NUM_REGS(NUM_REGS), .STROBE_IDX(STROBE_IDX), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o, .strobe_o(wr_strobe_o)
  );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic wr_strobe_o,
  input logic scl_s,
  input logic stop_det,
  input logic por_flag,
  input logic link_idle
);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_idle |-> !sda_oe_o);

  assert_oe_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o);

  assert_por_clear_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_flag) |-> $past(stop_det));

  assert_por_no_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_flag |=> !por_flag);
endmodule

bind tuner_ctrl_slave tcs_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .wr_strobe_o(wr_strobe_o),
  .scl_s(scl_s), .stop_det(stop_det), .por_flag(por_flag), .link_idle(link_idle)
);

// File: tb/tuner_ctrl_slave_tb_top.sv
module tuner_ctrl_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 40;
  localparam int NREG       = 12;
  localparam int WD_LIMIT   = 150000;
  localparam logic [6:0] DEV0 = 7'h60;
  localparam logic [6:0] DEV1 = 7'h61;
  // {addr_sel, pointer, data, expected strobe pulses}
  localparam logic [31:0] WR_VEC [6] = '{
    32'h00_00_0E_00, 32'h00_0B_5A_00, 32'h01_03_A5_00,
    32'h01_07_3C_00, 32'h00_04_99_01, 32'h01_09_FF_00
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [6:0] st1 = 7'h2A;
  logic [7:0] st2 = 8'hC3;
  logic sda_oe, strobe;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, strobe_cnt = 0, cyc = 0;
  logic [7:0] exp_regs [NREG];

  tuner_ctrl_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .status1_i(st1), .status2_i(st2), .regs_o(regs),
    .wr_strobe_o(strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (strobe) strobe_cnt <= strobe_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return 8'h80; 1: return 8'h23; 2: return 8'h02; 3: return 8'hF6;
      4: return 8'h84; 5: return 8'h01; 6: return 8'h80; 7: return 8'hCC;
      8: return 8'h4B; default: return 8'h00;
    endcase
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, $sformatf("reg %0d", i), 32'(regs[i*8 +: 8]), 32'(exp_regs[i]));
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
    acked = ~sda_bus;
    #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl_m = 1'b1; #Q; b[i] = sda_bus; #Q; scl_m = 1'b0;
    end
    // slave must release SDA for the master acknowledge slot
    #Q; chk("R7", "released in ack slot", 32'(sda_oe), 32'h0);
    sda_m = ~ack; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [6:0] dev, input logic [7:0] ptr, input logic [7:0] d [4],
                           input int n, input logic exp_ack, input string req);
    logic a;
    i2c_start();
    send_byte({dev, 1'b0}, a); chk(req, "address ack", 32'(a), 32'(exp_ack));
    send_byte(ptr, a);         chk(req, "pointer ack", 32'(a), 32'(exp_ack));
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);      chk(req, "data ack", 32'(a), 32'(exp_ack));
      if (exp_ack && (32'(ptr) + k) < NREG) exp_regs[32'(ptr) + k] = d[k];
    end
    i2c_stop();
    #(4*Q);
  endtask

  task automatic read_seq(input logic [6:0] dev, input logic ack_first,
                          output logic [7:0] b1, output logic [7:0] b2, input logic do_stop);
    logic a;
    i2c_start();
    send_byte({dev, 1'b1}, a); chk("R2", "read address ack", 32'(a), 32'h1);
    recv_byte(ack_first, b1);
    if (ack_first) recv_byte(1'b0, b2);
    else b2 = 8'h00;
    if (do_stop) begin i2c_stop(); #(4*Q); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    #(10*CLK_PERIOD); rst_n = 1'b1; #(10*CLK_PERIOD);
    for (int i = 0; i < NREG; i++) exp_regs[i] = dflt(i);
  endtask

  initial begin
    wait (cyc >= WD_LIMIT);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] b1, b2;
    logic a;
    int s0;

    do_reset();
    check_regs("R1");
    chk("R1", "sda_oe after reset", 32'(sda_oe), 32'h0);
    chk("R1", "strobe after reset", 32'(strobe_cnt), 32'h0);

    // table walk: single-byte writes under both address selections
    foreach (WR_VEC[v]) begin
      addr_sel = WR_VEC[v][24];
      s0 = strobe_cnt;
      d = '{WR_VEC[v][15:8], 8'h00, 8'h00, 8'h00};
      write_seq(addr_sel ? DEV1 : DEV0, WR_VEC[v][23:16], d, 1, 1'b1, "R2/R4");
      chk("R4", $sformatf("vector %0d reg", v), 32'(regs[32'(WR_VEC[v][23:16])*8 +: 8]), 32'(WR_VEC[v][15:8]));
      chk("R6", $sformatf("vector %0d strobe", v), 32'(strobe_cnt - s0), 32'(WR_VEC[v][7:0]));
    end
    addr_sel = 1'b0;

    // R4 burst with auto-increment
    d = '{8'h0E, 8'hD8, 8'hE1, 8'h00};
    write_seq(DEV0, 8'h00, d, 3, 1'b1, "R4");
    check_regs("R4");

    // R5 burst running past the last register
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    write_seq(DEV0, 8'h0A, d, 4, 1'b1, "R5");
    check_regs("R5");

    // R6 burst crossing register 0x04 strobes once
    s0 = strobe_cnt;
    d = '{8'h31, 8'h41, 8'h51, 8'h00};
    write_seq(DEV0, 8'h03, d, 3, 1'b1, "R6");
    chk("R6", "burst strobe count", 32'(strobe_cnt - s0), 32'h1);
    check_regs("R6");

    // R3 wrong address under each selection: no ack, no effect
    d = '{8'h77, 8'h66, 8'h00, 8'h00};
    write_seq(DEV1, 8'h02, d, 2, 1'b0, "R3");
    addr_sel = 1'b1;
    write_seq(DEV0, 8'h05, d, 2, 1'b0, "R3");
    addr_sel = 1'b0;
    check_regs("R3");

    // R8/R9: read cut short after byte 1 keeps the flag
    read_seq(DEV0, 1'b0, b1, b2, 1'b0);
    chk("R9", "byte1 with flag", 32'(b1), 32'hAA);
    for (int i = 0; i < 9; i++) begin
      #Q; scl_m = 1'b1; #Q;
      chk("R8", "no drive after nack", 32'(sda_bus), 32'h1);
      #Q; scl_m = 1'b0; #Q;
    end
    i2c_stop(); #(4*Q);

    // R7: full read, flag still set from power-on
    read_seq(DEV0, 1'b1, b1, b2, 1'b1);
    chk("R7", "status byte 1", 32'(b1), 32'hAA);
    chk("R7", "status byte 2", 32'(b2), 32'hC3);

    // R9: flag cleared by the previous complete read
    st1 = 7'h15; st2 = 8'h3C;
    read_seq(DEV0, 1'b1, b1, b2, 1'b1);
    chk("R9", "byte1 flag cleared", 32'(b1), 32'h15);
    chk("R7", "status byte 2 new", 32'(b2), 32'h3C);

    // R10: pointer then repeated START into a read
    i2c_start();
    send_byte({DEV0, 1'b0}, a); chk("R10", "address ack", 32'(a), 32'h1);
    send_byte(8'h08, a);        chk("R10", "pointer ack", 32'(a), 32'h1);
    read_seq(DEV0, 1'b1, b1, b2, 1'b1);
    chk("R10", "byte1 after restart", 32'(b1), 32'h15);
    chk("R10", "byte2 after restart", 32'(b2), 32'h3C);
    check_regs("R10");

    // R1/R9: second reset restores defaults and the flag
    do_reset();
    check_regs("R1");
    read_seq(DEV0, 1'b1, b1, b2, 1'b1);
    chk("R9", "flag back after reset", 32'(b1), 32'h95);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule